// File: doc/BRIEF.md
# Pulse-Burst Status Decoder

This block listens to a single status line that a processor toggles to report its state. It counts the rising edges that arrive close together and treats them as one burst. Once the line has been quiet for a set number of sampling ticks, the burst is over. The count is then matched against three known codes, and the matching sticky event flag is set. The three events are processor up and running, shutdown request and reboot request.

A supervising power sequencer uses the flags in two ways. It waits on the running flag before it enters its working state. It watches the other two flags to begin a power-down or a restart.

The block samples the line on a slow clock, nominally a 1 kHz tick divided down from the 50 MHz system clock. Every flag stays set until the sequencer pulses the clear input. The size of the most recent burst is always visible on a count output.

Top module: `burst_status_decoder`

## Requirements
- R1: While `rst` is high, and on the first sampling edge after it, all three flags and `last_count` are 0.
- R2: A burst of exactly 1 rising edge sets `flag_up`.
- R3: A burst of exactly 5 rising edges sets `flag_reboot`.
- R4: A burst of exactly 12 rising edges sets `flag_shutdown`.
- R5: A burst of any other length sets no flag. Its length still appears on `last_count`.
- R6: A burst ends only after `GAP_TICKS` sampling ticks (default 20) pass with no rising edge. Edges spaced closer than that count as one burst, and no flag changes before the gap has run out.
- R7: A set flag stays set until `clear` is high, so flags from separate bursts can be set together. A high `clear` zeroes all three flags on the next edge.
- R8: When `clear` is high in the cycle a burst ends, the flags stay 0. `last_count` still takes the new length.
- R9: The edge count saturates at 255. A longer burst reports 255 and sets no flag.
- R10: The status line passes through a two-flop synchroniser, and `last_count` holds the length of the most recent completed burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| status_in | input | 1 | Raw status line from the processor |
| clear | input | 1 | Clears all event flags; overrides a new event |
| flag_up | output | 1 | Sticky: processor running |
| flag_reboot | output | 1 | Sticky: reboot requested |
| flag_shutdown | output | 1 | Sticky: shutdown requested |
| last_count | output | 8 | Length of the last completed burst |

## Verification
The assertions assume that reset is applied from time zero and that `clear` is a level the sequencer controls, with no fixed relation to the status line. They also assume that a flag can first rise only at the end of a burst. The stimulus keeps to these assumptions in three ways. It drives the status line and `clear` on the falling clock edge. Inside a burst, it never spaces rising edges more than `GAP_TICKS-3` ticks apart. Between bursts, it keeps the line low for well beyond the gap, so each burst is seen as a single unit.

// File: rtl/burst_status_decoder.sv
module burst_status_decoder #(
  parameter int CNT_W          = 8,
  parameter int GAP_TICKS      = 20,
  parameter int UP_COUNT       = 1,
  parameter int REBOOT_COUNT   = 5,
  parameter int SHUTDOWN_COUNT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             status_in,
  input  logic             clear,
  output logic             flag_up,
  output logic             flag_reboot,
  output logic             flag_shutdown,
  output logic [CNT_W-1:0] last_count
);

  localparam int GAP_W = $clog2(GAP_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] pulse_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic             rise, burst_done;

  assign rise       = sync_q[1] & ~sync_q[2];
  assign burst_done = (pulse_cnt != '0) && !rise && (gap_cnt == GAP_W'(GAP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], status_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_cnt <= '0;
      gap_cnt   <= '0;
    end else if (rise) begin
      pulse_cnt <= (pulse_cnt == CNT_MAX) ? pulse_cnt : pulse_cnt + 1'b1;
      gap_cnt   <= '0;
    end else if (burst_done) begin
      pulse_cnt <= '0;
      gap_cnt   <= '0;
    end else if (pulse_cnt != '0) begin
      gap_cnt   <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_up       <= 1'b0;
      flag_reboot   <= 1'b0;
      flag_shutdown <= 1'b0;
      last_count    <= '0;
    end else begin
      if (burst_done) last_count <= pulse_cnt;
      if (clear) begin
        flag_up       <= 1'b0;
        flag_reboot   <= 1'b0;
        flag_shutdown <= 1'b0;
      end else if (burst_done) begin
        flag_up       <= flag_up       | (pulse_cnt == CNT_W'(UP_COUNT));
        flag_reboot   <= flag_reboot   | (pulse_cnt == CNT_W'(REBOOT_COUNT));
        flag_shutdown <= flag_shutdown | (pulse_cnt == CNT_W'(SHUTDOWN_COUNT));
      end
    end
  end

endmodule

// File: rtl/burst_status_decoder_chk.sv
module burst_status_decoder_chk #(
  parameter int CNT_W          = 8,
  parameter int UP_COUNT       = 1,
  parameter int REBOOT_COUNT   = 5,
  parameter int SHUTDOWN_COUNT = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             flag_up,
  input logic             flag_reboot,
  input logic             flag_shutdown,
  input logic [CNT_W-1:0] last_count
);

  assert_reset_R1: assert property (@(posedge clk) rst |=> !flag_up && !flag_reboot && !flag_shutdown && last_count == '0);

  assert_up_code_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_up) |-> last_count == CNT_W'(UP_COUNT));

  assert_reboot_code_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_reboot) |-> last_count == CNT_W'(REBOOT_COUNT));

  assert_shutdown_code_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_shutdown) |-> last_count == CNT_W'(SHUTDOWN_COUNT));

  assert_one_event_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({$rose(flag_up), $rose(flag_reboot), $rose(flag_shutdown)}));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!clear && (flag_up || flag_reboot || flag_shutdown)) |=>
      ($past(flag_up) -> flag_up) && ($past(flag_reboot) -> flag_reboot) &&
      ($past(flag_shutdown) -> flag_shutdown));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !flag_up && !flag_reboot && !flag_shutdown);

  assert_event_needs_count_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_up) || $rose(flag_reboot) || $rose(flag_shutdown)) |-> !$past(clear));

endmodule

bind burst_status_decoder burst_status_decoder_chk #(
  .CNT_W(CNT_W), .UP_COUNT(UP_COUNT),
  .REBOOT_COUNT(REBOOT_COUNT), .SHUTDOWN_COUNT(SHUTDOWN_COUNT)
) chk (
  .clk(clk), .rst(rst), .clear(clear), .flag_up(flag_up),
  .flag_reboot(flag_reboot), .flag_shutdown(flag_shutdown), .last_count(last_count)
);

// File: tb/burst_status_decoder_test.sv
`timescale 1ns/1ps
module burst_status_decoder_test;
  localparam int GAP = 20;

  logic clk = 1'b0, rst = 1'b1, status_in = 1'b0, clear = 1'b0;
  logic flag_up, flag_reboot, flag_shutdown;
  logic [7:0] last_count;

  int checks = 0, errors = 0;
  logic exp_up = 0, exp_rb = 0, exp_sd = 0;
  logic [7:0] exp_cnt = 0;

  always #2.5 clk = ~clk;

  burst_status_decoder uut (
    .clk(clk), .rst(rst), .status_in(status_in), .clear(clear),
    .flag_up(flag_up), .flag_reboot(flag_reboot), .flag_shutdown(flag_shutdown),
    .last_count(last_count)
  );

  function automatic logic [7:0] sat_count(int n);
    return (n > 255) ? 8'd255 : 8'(n);
  endfunction

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic verify(string req);
    check(req, flag_up, exp_up, "flag_up");
    check(req, flag_reboot, exp_rb, "flag_reboot");
    check(req, flag_shutdown, exp_sd, "flag_shutdown");
    check(req, last_count, exp_cnt, "last_count");
  endtask

  task automatic pulse(int hi, int lo);
    status_in = 1'b1;
    repeat (hi) @(negedge clk);
    status_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic model(int n, logic clr);
    exp_cnt = sat_count(n);
    if (clr) begin
      exp_up = 0; exp_rb = 0; exp_sd = 0;
    end else begin
      if (exp_cnt == 8'd1)  exp_up = 1;
      if (exp_cnt == 8'd5)  exp_rb = 1;
      if (exp_cnt == 8'd12) exp_sd = 1;
    end
  endtask

  task automatic burst(int n, logic rnd);
    for (int i = 0; i < n; i++)
      if (rnd) pulse($urandom_range(1, 3), $urandom_range(1, GAP - 6));
      else     pulse(1, 2);
    repeat (GAP + 8) @(negedge clk);
    model(n, clear);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    @(negedge clk);
    exp_up = 0; exp_rb = 0; exp_sd = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    verify("R1");
    rst = 1'b0;
    @(negedge clk);
    verify("R1");

    burst(1, 0);  verify("R2");
    do_clear();   verify("R7");
    burst(5, 0);  verify("R3");
    burst(12, 0); verify("R4");
    burst(7, 0);  verify("R5");
    burst(13, 0); verify("R5");
    do_clear();   verify("R7");

    // R6: edges spaced just under the gap stay one burst
    pulse(1, GAP - 5);
    verify("R6");
    for (int i = 0; i < 4; i++) pulse(1, GAP - 5);
    repeat (GAP + 8) @(negedge clk);
    model(5, 1'b0);
    verify("R6");
    burst(1, 0);
    burst(1, 0);
    verify("R6");

    // R8: clear held while a burst ends
    clear = 1'b1;
    burst(12, 0);
    verify("R8");
    clear = 1'b0;
    @(negedge clk);

    burst(300, 0); verify("R9");
    burst(255, 0); verify("R9");
    burst(2, 0);   verify("R10");

    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 5) == 0) do_clear();
      burst($urandom_range(1, 14), 1);
      verify("R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule